// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects up to eight interrupt request lines, resolves them by fixed priority and raises one interrupt output toward a processor. Software reaches it through a small register interface with three addresses: a control port, an auxiliary port and a trigger-mode register. The control port takes command words and, by default, reads back the pending requests. The auxiliary port takes the initialisation words and, once those are done, the mask. Any control-port write with bit 4 set restarts initialisation. The auxiliary writes that follow then load the vector base, the cascade word and, if it was asked for, a processor-mode word.

Once initialised, software masks inputs, signals end of interrupt and chooses what control-port reads return. It can also poll. A poll read returns the level that wins arbitration and puts that level in service, so the controller can run without a bus acknowledge cycle. Each input is edge or level triggered, chosen by its own bit in the trigger-mode register. The block reports the vector of the winning request, which is the programmed base plus the level number.

Top module: `pic_core`

## Requirements
- R1: After reset, int_out is 0, the mask register reads 0xFF on the auxiliary port (addr 1), control-port reads (addr 0) return the request register, and the trigger-mode register (addr 2) reads 0x00.
- R2: A control-port write with bit 4 set restarts initialisation. In the following cycle the mask is 0xFF, the in-service register is clear, control-port reads return the request register and every latched edge request is dropped. Bit 0 of that word set means a mode word is expected; clear means it is skipped and mode_word keeps its value.
- R3: After the restart word, auxiliary writes load in order the vector base (bits 7:3 only; bits 2:0 are dropped), then cascade_word, then mode_word when one was requested. Every later auxiliary write loads the mask.
- R4: A mask bit of 1 stops its input from raising int_out and from winning a poll. The request itself stays recorded.
- R5: Input 0 has the highest priority and input 7 the lowest. int_out is 1 only when some unmasked request has a higher priority than every level now in service.
- R6: A control-port write with bits 7:5 = 001 and bits 4:3 = 00 (for example 0x20) clears the in-service bit of the highest-priority level in service.
- R7: A control-port write with bits 7:5 = 011 and bits 4:3 = 00 clears in-service bit n, where n is bits 2:0 (for example 0x63 clears bit 3).
- R8: A control-port write with bit 4 = 0 and bit 3 = 1 selects what control-port reads return. Bits 1:0 = 11 select the in-service register and 10 selects the request register. Values 00 and 01 leave the selection as it was.
- R9: A select write with bit 2 set (0x0C) arms a poll. The next control-port read returns bit 7 = 1 and the winning level in bits 2:0, sets that level's in-service bit and clears an edge request on that level. With no eligible request it returns 0x00 and changes nothing. Later reads return the selected register again.
- R10: The trigger-mode register (addr 2) reads back what was written. A bit of 0 latches a request on a rising input, and the request holds until a poll takes it. A bit of 1 makes the request follow the input, one clock later.
- R11: vector_out equals the vector base plus the number of the highest-priority unmasked request, and is meaningful while int_out is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe for one cycle |
| rd_en | input | 1 | Register read strobe for one cycle |
| addr | input | 2 | 0 control port, 1 auxiliary port, 2 trigger-mode register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational while rd_en is 1 |
| irq_in | input | 8 | Interrupt request lines, synchronous to clk |
| int_out | output | 1 | Interrupt request toward the processor |
| vector_out | output | 8 | Vector of the current winning request |
| cascade_word | output | 8 | Stored cascade configuration word |
| mode_word | output | 8 | Stored processor-mode word |

## Verification
The bench builds the block at its package defaults: eight lines and eight-bit data. At that size every level from 0 to 7 can be driven and polled, and all three bits of the level field appear in poll results and vectors. Two vector bases, 0x40 and a written 0x8D stored as 0x88, show that only bits 7:3 of the base are kept. Re-initialising with a level still in service and with stale edge requests present shows that the restart clears both.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int unsigned PIC_LINES = 8;
    localparam int unsigned LVL_W     = $clog2(PIC_LINES);
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned ADDR_W    = 2;

    localparam logic [ADDR_W-1:0] PORT_CTL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] PORT_AUX  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] PORT_TRIG = ADDR_W'(2);

    typedef enum logic [1:0] {
        INIT_BASE,
        INIT_CASC,
        INIT_MODE,
        INIT_RUN
    } init_state_t;

    typedef enum logic {
        SEL_REQ,
        SEL_SVC
    } read_sel_t;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] idx;
    } prio_t;

    typedef struct packed {
        logic             restart;
        logic             eoi_top;
        logic             eoi_lvl;
        logic [LVL_W-1:0] eoi_idx;
        logic             sel_upd;
        read_sel_t        sel_val;
        logic             poll_arm;
    } ctl_cmd_t;

    // Lowest index set wins: input 0 has top priority.
    function automatic prio_t lowest_set(input logic [PIC_LINES-1:0] v);
        prio_t r;
        r = '0;
        for (int i = PIC_LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.valid = 1'b1;
                r.idx   = LVL_W'(i);
            end
        end
        return r;
    endfunction

    function automatic logic [PIC_LINES-1:0] level_bit(input logic [LVL_W-1:0] l);
        return PIC_LINES'(1) << l;
    endfunction

    function automatic ctl_cmd_t decode_ctl(input logic [DATA_W-1:0] d);
        ctl_cmd_t c;
        c = '0;
        if (d[4]) begin
            c.restart = 1'b1;
        end else if (!d[3]) begin
            if (d[7:5] == 3'b001) begin
                c.eoi_top = 1'b1;
            end else if (d[7:5] == 3'b011) begin
                c.eoi_lvl = 1'b1;
                c.eoi_idx = d[LVL_W-1:0];
            end
        end else begin
            c.poll_arm = d[2];
            if (d[1]) begin
                c.sel_upd = 1'b1;
                c.sel_val = d[0] ? SEL_SVC : SEL_REQ;
            end
        end
        return c;
    endfunction
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart_wr,
    input  logic              aux_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] vec_base,
    output logic [DATA_W-1:0] casc_word,
    output logic [DATA_W-1:0] mode_word,
    output logic              mask_wr
);
    init_state_t state_q;
    logic        want_mode_q;

    assign mask_wr = aux_wr && (state_q == INIT_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= INIT_RUN;
            want_mode_q <= 1'b0;
            vec_base    <= '0;
            casc_word   <= '0;
            mode_word   <= '0;
        end else if (restart_wr) begin
            state_q     <= INIT_BASE;
            want_mode_q <= wdata[0];
        end else if (aux_wr) begin
            case (state_q)
                INIT_BASE: begin
                    vec_base <= {wdata[DATA_W-1:LVL_W], LVL_W'(0)};
                    state_q  <= INIT_CASC;
                end
                INIT_CASC: begin
                    casc_word <= wdata;
                    state_q   <= want_mode_q ? INIT_MODE : INIT_RUN;
                end
                INIT_MODE: begin
                    mode_word <= wdata;
                    state_q   <= INIT_RUN;
                end
                default: state_q <= INIT_RUN;
            endcase
        end
    end
endmodule

// File: rtl/pic_cmd_unit.sv
module pic_cmd_unit
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic              poll_read,
    input  logic [DATA_W-1:0] wdata,
    output ctl_cmd_t          cmd,
    output read_sel_t         read_sel,
    output logic              poll_armed
);
    assign cmd = ctl_wr ? decode_ctl(wdata) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            read_sel   <= SEL_REQ;
            poll_armed <= 1'b0;
        end else if (cmd.restart) begin
            read_sel   <= SEL_REQ;
            poll_armed <= 1'b0;
        end else begin
            if (cmd.sel_upd) begin
                read_sel <= cmd.sel_val;
            end
            if (cmd.poll_arm) begin
                poll_armed <= 1'b1;
            end else if (poll_read) begin
                poll_armed <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pic_req_bank.sv
module pic_req_bank
    import pic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic [PIC_LINES-1:0] irq_in,
    input  logic [PIC_LINES-1:0] trig_level,
    input  logic [PIC_LINES-1:0] ack_vec,
    output logic [PIC_LINES-1:0] irr
);
    for (genvar g = 0; g < PIC_LINES; g++) begin : g_line
        logic prev_q;
        logic edge_q;
        logic lvl_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= 1'b0;
                edge_q <= 1'b0;
                lvl_q  <= 1'b0;
            end else begin
                prev_q <= irq_in[g];
                lvl_q  <= irq_in[g];
                if (flush) begin
                    edge_q <= 1'b0;
                end else begin
                    edge_q <= (irq_in[g] && !prev_q) || (edge_q && !ack_vec[g]);
                end
            end
        end

        assign irr[g] = trig_level[g] ? lvl_q : edge_q;
    end
endmodule

// File: rtl/pic_core.sv
module pic_core
    import pic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    input  logic [PIC_LINES-1:0] irq_in,
    output logic                 int_out,
    output logic [DATA_W-1:0]    vector_out,
    output logic [DATA_W-1:0]    cascade_word,
    output logic [DATA_W-1:0]    mode_word
);
    logic                 ctl_wr, aux_wr, trig_wr, mask_wr;
    logic                 poll_read, poll_take, poll_armed;
    ctl_cmd_t             cmd;
    read_sel_t            read_sel;
    logic [DATA_W-1:0]    vec_base;
    logic [PIC_LINES-1:0] mask_q, trig_q, isr_q, irr;
    logic [PIC_LINES-1:0] take_vec, eoi_vec;
    prio_t                svc, req;
    logic                 eligible;
    logic [DATA_W-1:0]    poll_word;

    assign ctl_wr  = wr_en && (addr == PORT_CTL);
    assign aux_wr  = wr_en && (addr == PORT_AUX);
    assign trig_wr = wr_en && (addr == PORT_TRIG);

    pic_init_seq u_init (
        .clk        (clk),
        .rst        (rst),
        .restart_wr (cmd.restart),
        .aux_wr     (aux_wr),
        .wdata      (wdata),
        .vec_base   (vec_base),
        .casc_word  (cascade_word),
        .mode_word  (mode_word),
        .mask_wr    (mask_wr)
    );

    pic_cmd_unit u_cmd (
        .clk        (clk),
        .rst        (rst),
        .ctl_wr     (ctl_wr),
        .poll_read  (poll_read),
        .wdata      (wdata),
        .cmd        (cmd),
        .read_sel   (read_sel),
        .poll_armed (poll_armed)
    );

    pic_req_bank u_req (
        .clk        (clk),
        .rst        (rst),
        .flush      (cmd.restart),
        .irq_in     (irq_in),
        .trig_level (trig_q),
        .ack_vec    (take_vec),
        .irr        (irr)
    );

    // Arbitration against the highest level already in service.
    assign svc      = lowest_set(isr_q);
    assign req      = lowest_set(irr & ~mask_q);
    assign eligible = req.valid && (!svc.valid || (req.idx < svc.idx));
    assign int_out  = eligible;

    assign vector_out = vec_base + DATA_W'(req.idx);

    assign poll_read = rd_en && (addr == PORT_CTL) && poll_armed;
    assign poll_take = poll_read && eligible;
    assign take_vec  = poll_take ? level_bit(req.idx) : '0;

    always_comb begin
        eoi_vec = '0;
        if (cmd.eoi_top && svc.valid) begin
            eoi_vec = level_bit(svc.idx);
        end else if (cmd.eoi_lvl) begin
            eoi_vec = level_bit(cmd.eoi_idx);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.restart) begin
            isr_q <= '0;
        end else begin
            isr_q <= (isr_q & ~eoi_vec) | take_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.restart) begin
            mask_q <= '1;
        end else if (mask_wr) begin
            mask_q <= wdata[PIC_LINES-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= '0;
        end else if (trig_wr) begin
            trig_q <= wdata[PIC_LINES-1:0];
        end
    end

    always_comb begin
        poll_word = '0;
        if (eligible) begin
            poll_word[DATA_W-1]  = 1'b1;
            poll_word[LVL_W-1:0] = req.idx;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                PORT_CTL: begin
                    if (poll_armed) begin
                        rdata = poll_word;
                    end else if (read_sel == SEL_SVC) begin
                        rdata = DATA_W'(isr_q);
                    end else begin
                        rdata = DATA_W'(irr);
                    end
                end
                PORT_AUX:  rdata = DATA_W'(mask_q);
                PORT_TRIG: rdata = DATA_W'(trig_q);
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk
    import pic_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [DATA_W-1:0]    wdata,
    input logic                 int_out,
    input logic [DATA_W-1:0]    vector_out,
    input logic [PIC_LINES-1:0] irr,
    input logic [PIC_LINES-1:0] isr,
    input logic [PIC_LINES-1:0] mask,
    input logic                 poll_armed
);
    // R2
    restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == PORT_CTL && wdata[4]) |=> (mask == '1 && isr == '0));

    // R5
    int_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((irr & ~mask) != '0));

    // R9
    poll_marks_svc_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && addr == PORT_CTL && poll_armed && int_out)
        |=> ($countones(isr) == $past($countones(isr)) + 1));

    // R6
    eoi_drops_one_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && addr == PORT_CTL && wdata == 8'h20 && isr != '0)
        |=> ($countones(isr) + 1 == $past($countones(isr))));

    // R3
    base_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == PORT_AUX) |=> $stable(vector_out[DATA_W-1:LVL_W]));
endmodule

bind pic_core pic_core_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .int_out    (int_out),
    .vector_out (vector_out),
    .irr        (irr),
    .isr        (isr_q),
    .mask       (mask_q),
    .poll_armed (poll_armed)
);

// File: tb/pic_core_tb_top.sv
module pic_core_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] irq_in = 8'h00;
    logic       int_out;
    logic [7:0] vector_out;
    logic [7:0] cascade_word;
    logic [7:0] mode_word;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pic_core dut_i (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .addr         (addr),
        .wdata        (wdata),
        .rdata        (rdata),
        .irq_in       (irq_in),
        .int_out      (int_out),
        .vector_out   (vector_out),
        .cascade_word (cascade_word),
        .mode_word    (mode_word)
    );

    // {irq_in, mask, expected poll word}; all lines level triggered, base 0x40
    localparam int NVEC = 7;
    localparam logic [23:0] VEC_TBL [NVEC] = '{
        {8'h00, 8'h00, 8'h00},
        {8'h01, 8'h00, 8'h80},
        {8'hF0, 8'h00, 8'h84},
        {8'hF0, 8'h10, 8'h85},
        {8'h80, 8'h00, 8'h87},
        {8'hFF, 8'hFF, 8'h00},
        {8'h0C, 8'h04, 8'h83}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%02h expected=%02h", 8'h01, 8'h00);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 int_out", {7'd0, int_out}, 8'h00);
        rd(2'd1, v); check("R1 mask", v, 8'hFF);
        rd(2'd0, v); check("R1 ctl read irr", v, 8'h00);
        rd(2'd2, v); check("R1 trig", v, 8'h00);

        // R2 R3 full init with mode word
        wr(2'd0, 8'h11);
        wr(2'd1, 8'h45);
        wr(2'd1, 8'h04);
        wr(2'd1, 8'h01);
        check("R3 cascade", cascade_word, 8'h04);
        check("R3 mode", mode_word, 8'h01);
        rd(2'd1, v); check("R3 mask still set", v, 8'hFF);
        wr(2'd1, 8'h00);
        rd(2'd1, v); check("R3 mask after init", v, 8'h00);

        // R10 trigger register readback, all level
        wr(2'd2, 8'hFF);
        rd(2'd2, v); check("R10 trig readback", v, 8'hFF);

        // R4 R5 R9 R11 table
        for (int i = 0; i < NVEC; i++) begin
            irq_in = VEC_TBL[i][23:16];
            wr(2'd1, VEC_TBL[i][15:8]);
            check($sformatf("R4 R5 int_out entry %0d", i), {7'd0, int_out}, {7'd0, VEC_TBL[i][7]});
            if (VEC_TBL[i][7])
                check($sformatf("R11 vector entry %0d", i), vector_out, 8'h40 | {5'd0, VEC_TBL[i][2:0]});
            wr(2'd0, 8'h0C);
            rd(2'd0, v);
            check($sformatf("R9 poll entry %0d", i), v, VEC_TBL[i][7:0]);
            wr(2'd0, 8'h20);
        end

        // R5 R6 R7 R8 nesting
        wr(2'd1, 8'h00);
        irq_in = 8'h08;
        tick();
        wr(2'd0, 8'h0C);
        rd(2'd0, v); check("R9 poll level3", v, 8'h83);
        wr(2'd0, 8'h0B);
        rd(2'd0, v); check("R8 isr select", v, 8'h08);
        irq_in = 8'h28;
        tick();
        check("R5 lower level blocked", {7'd0, int_out}, 8'h00);
        irq_in = 8'h2A;
        tick();
        check("R5 higher level passes", {7'd0, int_out}, 8'h01);
        check("R11 vector level1", vector_out, 8'h41);
        wr(2'd0, 8'h0C);
        rd(2'd0, v); check("R9 poll level1", v, 8'h81);
        rd(2'd0, v); check("R9 read after poll isr", v, 8'h0A);
        wr(2'd0, 8'h20);
        rd(2'd0, v); check("R6 nonspecific eoi", v, 8'h08);
        wr(2'd0, 8'h63);
        rd(2'd0, v); check("R7 specific eoi", v, 8'h00);
        wr(2'd0, 8'h08);
        rd(2'd0, v); check("R8 select 00 ignored", v, 8'h00);
        wr(2'd0, 8'h0A);
        rd(2'd0, v); check("R8 irr select", v, 8'h2A);

        // R2 restart without mode word while a level is in service
        wr(2'd0, 8'h0C);
        rd(2'd0, v); check("R9 poll before restart", v, 8'h81);
        wr(2'd0, 8'h10);
        rd(2'd1, v); check("R2 mask set by restart", v, 8'hFF);
        wr(2'd0, 8'h0B);
        rd(2'd0, v); check("R2 isr cleared", v, 8'h00);
        wr(2'd1, 8'h8D);
        wr(2'd1, 8'h02);
        wr(2'd1, 8'h00);
        rd(2'd1, v); check("R2 third aux goes to mask", v, 8'h00);
        check("R2 mode kept", mode_word, 8'h01);
        check("R3 cascade 2", cascade_word, 8'h02);

        // R10 edge and level behaviour
        irq_in = 8'h00;
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h0A);
        rd(2'd0, v); check("R10 no stale edge", v, 8'h00);
        irq_in = 8'h10;
        tick();
        irq_in = 8'h00;
        tick();
        rd(2'd0, v); check("R10 edge latched", v, 8'h10);
        check("R3 R11 vector base 0x88", vector_out, 8'h8C);
        wr(2'd2, 8'h01);
        irq_in = 8'h01;
        tick();
        rd(2'd0, v); check("R10 level follows high", v, 8'h11);
        check("R11 vector level0", vector_out, 8'h88);
        irq_in = 8'h00;
        tick();
        rd(2'd0, v); check("R10 level follows low", v, 8'h10);
        wr(2'd0, 8'h0C);
        rd(2'd0, v); check("R9 R10 poll edge level", v, 8'h84);
        rd(2'd0, v); check("R10 edge cleared by poll", v, 8'h00);
        rd(2'd2, v); check("R10 trig readback 2", v, 8'h01);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule